// File: doc/BRIEF.md
# Function-Reset Identity Word Keeper

This block protects a PCIe function's programmed identity word (configuration word 0) across a function level reset. Once a reset wipes that word back to its power-on value, the block puts the programmed value back. It runs without software. A tick-enable input starts one evaluation pass every 100 µs. A microsecond strobe drives a free-running time base that times each function's wait.

A pass runs only if two things are true at the tick:

- The link-training field of the debug word reads L0.
- At least one stop-request bit (one per physical function) is set.

During the pass, each function whose stop bit is set gets its timer armed. If that function has no saved identity word yet, the word is captured as well. Next, every function whose timer has run longer than the wait window has word 0 read again. A reverted word causes two actions, in this order:

1. The block pulses that function's stop-bit clear.
2. The block writes the saved word back.

A word that has not reverted leaves the function armed, and it is checked again on a later tick. Configuration accesses use a request/acknowledge port with one access outstanding at a time.

The sequencer has these states:

| State | Role |
|---|---|
| IDLE | Waits for a tick |
| ARM | Per function: arms the timer and decides on a capture |
| CAP | Capture read |
| CHK | Per function: checks whether the wait window has expired |
| VERIFY | Read-back of word 0 |
| RELEASE | Stop-bit clear pulse |
| RESTORE | Write-back of the saved word |

Its transitions are:

- IDLE→ARM on a qualified tick.
- ARM→CAP when the function is stopped and nothing is saved.
- ARM→ARM or ARM→CHK to step to the next function.
- CAP→ARM or CAP→CHK on acknowledge.
- CHK→VERIFY when the function is armed and expired.
- CHK→CHK or CHK→IDLE to step on.
- VERIFY→RELEASE on a mismatch.
- VERIFY→CHK or VERIFY→IDLE on a match.
- RELEASE→RESTORE.
- RESTORE→CHK or RESTORE→IDLE on acknowledge.

Top module: `flr_id_keeper`

## Requirements
- R1: A tick on which debug bits [8:3] are not 0x11 (L0) starts no configuration access and no stop-bit clear, even with a stop bit set.
- R2: A tick in L0 with both stop bits clear starts no configuration access.
- R3: A function whose stop bit is set and whose saved word is zero gets one capture read. The read has cfg_we_o=0 and address = function number in bits [31:24] with bits [23:0] zero. The returned data becomes the saved word.
- R4: A later stop of a function whose saved word is nonzero makes no capture read.
- R5: No read-back of a function happens until its elapsed time, counted from the tick that armed it, exceeds WAIT_US microseconds.
- R6: A read-back that differs from the saved word causes one single-cycle pulse on stop_clr_o. The pulse sets bit index = function number and no other bit. The next access is then a write (cfg_we_o=1) of the saved word to that function's word 0.
- R7: A read-back equal to the saved word causes no clear and no write. The function stays armed and is read back again on the next tick.
- R8: Within a pass, function 0 is serviced before function 1. While a request waits for acknowledge, its address, direction and write data do not change.
- R9: During and right after reset, cfg_req_o and stop_clr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse starting an evaluation pass (100 µs cadence) |
| us_tick_i | input | 1 | One-cycle microsecond strobe for the time base |
| ltssm_dbg_i | input | DBG_W | Debug word; bits [8:3] hold the link-training state |
| stop_i | input | NUM_PF | Current stop-request bit per function |
| stop_clr_o | output | NUM_PF | Write-one-to-clear pulse for the stop bits |
| cfg_req_o | output | 1 | Configuration access request |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_addr_o | output | 32 | Function number in [31:24], register offset in [23:0] |
| cfg_wdata_o | output | DATA_W | Write data |
| cfg_ack_i | input | 1 | Access acknowledge; read data valid with it |
| cfg_rdata_i | input | DATA_W | Read data |

## Verification
The assertions check the port protocol on every cycle:

- A pending request holds its address, direction and data.
- Addresses always point at register offset zero.
- The clear pulse is one-hot, and no request is active during it.
- Every clear is followed by a write request.

Only the bench scenarios can show the decisions that depend on history:

- L0 and stop-bit gating on a tick.
- Capture happening only once.
- The wait window being honoured.
- Retry when the word has not reverted.
- Function 0 being serviced before function 1 when both expire together.

// File: rtl/flr_pkg.sv
package flr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CAP,
        ST_CHK,
        ST_VERIFY,
        ST_RELEASE,
        ST_RESTORE
    } flr_state_e;

    localparam int          LTSSM_FIELD_W = 6;
    localparam logic [5:0]  LTSSM_L0      = 6'h11;
    localparam int          FN_SHIFT      = 24;

endpackage

// File: rtl/flr_us_clock.sv
module flr_us_clock #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick_i,
    output logic [TW-1:0] now_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            now_o <= '0;
        else if (us_tick_i)
            now_o <= now_o + TW'(1);
    end

endmodule

// File: rtl/flr_pf_slot.sv
module flr_pf_slot #(
    parameter int DATA_W = 32,
    parameter int TW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     now_i,
    input  logic              arm_i,
    input  logic              cap_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              running_o,
    output logic [DATA_W-1:0] saved_o,
    output logic [TW-1:0]     elapsed_o
);

    logic [TW-1:0] start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            start_q   <= '0;
            saved_o   <= '0;
        end else begin
            if (arm_i) begin
                running_o <= 1'b1;
                start_q   <= now_i;
            end else if (done_i) begin
                running_o <= 1'b0;
            end
            if (cap_i)
                saved_o <= data_i;
        end
    end

    // Modular difference stays correct across a wrap of the time base.
    assign elapsed_o = now_i - start_q;

endmodule

// File: rtl/flr_id_keeper.sv
module flr_id_keeper
    import flr_pkg::*;
#(
    parameter int NUM_PF    = 2,
    parameter int DATA_W    = 32,
    parameter int TW        = 32,
    parameter int WAIT_US   = 99700,
    parameter int DBG_W     = 16,
    parameter int LTSSM_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              us_tick_i,
    input  logic [DBG_W-1:0]  ltssm_dbg_i,
    input  logic [NUM_PF-1:0] stop_i,
    output logic [NUM_PF-1:0] stop_clr_o,
    output logic              cfg_req_o,
    output logic              cfg_we_o,
    output logic [31:0]       cfg_addr_o,
    output logic [DATA_W-1:0] cfg_wdata_o,
    input  logic              cfg_ack_i,
    input  logic [DATA_W-1:0] cfg_rdata_i
);

    localparam int PF_W = (NUM_PF > 1) ? $clog2(NUM_PF) : 1;
    localparam logic [PF_W-1:0] LAST_PF = PF_W'(NUM_PF - 1);
    localparam logic [TW-1:0]   WAIT_LIM = TW'(WAIT_US);

    flr_state_e        state_q, state_d;
    logic [PF_W-1:0]   pf_q, pf_d, pf_nxt;
    logic [NUM_PF-1:0] stop_q;
    logic [NUM_PF-1:0] arm_v, cap_v, done_v, running_v;
    logic [DATA_W-1:0] saved_a   [NUM_PF];
    logic [TW-1:0]     elapsed_a [NUM_PF];
    logic [TW-1:0]     now_w;
    logic              link_l0, last_pf, stop_sel, run_sel, expired;
    logic [DATA_W-1:0] saved_sel;

    flr_us_clock #(.TW(TW)) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick_i (us_tick_i),
        .now_o     (now_w)
    );

    for (genvar g = 0; g < NUM_PF; g++) begin : g_slot
        flr_pf_slot #(.DATA_W(DATA_W), .TW(TW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .now_i     (now_w),
            .arm_i     (arm_v[g]),
            .cap_i     (cap_v[g]),
            .done_i    (done_v[g]),
            .data_i    (cfg_rdata_i),
            .running_o (running_v[g]),
            .saved_o   (saved_a[g]),
            .elapsed_o (elapsed_a[g])
        );
    end

    assign link_l0   = (ltssm_dbg_i[LTSSM_LSB +: LTSSM_FIELD_W] == LTSSM_L0);
    assign last_pf   = (pf_q == LAST_PF);
    assign pf_nxt    = pf_q + PF_W'(1);
    assign stop_sel  = stop_q[pf_q];
    assign run_sel   = running_v[pf_q];
    assign saved_sel = saved_a[pf_q];
    assign expired   = (elapsed_a[pf_q] > WAIT_LIM);

    // State register and pass bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pf_q    <= '0;
            stop_q  <= '0;
        end else begin
            state_q <= state_d;
            pf_q    <= pf_d;
            if (state_q == ST_IDLE)
                stop_q <= stop_i;
        end
    end

    // Next state and per-function strobes.
    always_comb begin
        state_d = state_q;
        pf_d    = pf_q;
        arm_v   = '0;
        cap_v   = '0;
        done_v  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i && link_l0 && (|stop_i)) begin
                    state_d = ST_ARM;
                    pf_d    = '0;
                end
            end
            ST_ARM: begin
                if (stop_sel && !run_sel)
                    arm_v[pf_q] = 1'b1;
                if (stop_sel && (saved_sel == '0)) begin
                    state_d = ST_CAP;
                end else begin
                    state_d = last_pf ? ST_CHK : ST_ARM;
                    pf_d    = last_pf ? '0 : pf_nxt;
                end
            end
            ST_CAP: begin
                if (cfg_ack_i) begin
                    cap_v[pf_q] = 1'b1;
                    state_d = last_pf ? ST_CHK : ST_ARM;
                    pf_d    = last_pf ? '0 : pf_nxt;
                end
            end
            ST_CHK: begin
                if (run_sel && expired) begin
                    state_d = ST_VERIFY;
                end else begin
                    state_d = last_pf ? ST_IDLE : ST_CHK;
                    pf_d    = last_pf ? '0 : pf_nxt;
                end
            end
            ST_VERIFY: begin
                if (cfg_ack_i) begin
                    if (cfg_rdata_i != saved_sel) begin
                        state_d = ST_RELEASE;
                    end else begin
                        state_d = last_pf ? ST_IDLE : ST_CHK;
                        pf_d    = last_pf ? '0 : pf_nxt;
                    end
                end
            end
            ST_RELEASE: begin
                state_d = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (cfg_ack_i) begin
                    done_v[pf_q] = 1'b1;
                    state_d = last_pf ? ST_IDLE : ST_CHK;
                    pf_d    = last_pf ? '0 : pf_nxt;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state.
    always_comb begin
        cfg_req_o   = (state_q == ST_CAP) || (state_q == ST_VERIFY) ||
                      (state_q == ST_RESTORE);
        cfg_we_o    = (state_q == ST_RESTORE);
        cfg_addr_o  = 32'(pf_q) << FN_SHIFT;
        cfg_wdata_o = saved_sel;
        stop_clr_o  = '0;
        if (state_q == ST_RELEASE)
            stop_clr_o[pf_q] = 1'b1;
    end

endmodule

// File: rtl/flr_id_keeper_chk.sv
module flr_id_keeper_chk #(
    parameter int NUM_PF = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req_o,
    input logic              cfg_we_o,
    input logic [31:0]       cfg_addr_o,
    input logic [DATA_W-1:0] cfg_wdata_o,
    input logic              cfg_ack_i,
    input logic [NUM_PF-1:0] stop_clr_o
);

    assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_o && !cfg_ack_i) |=> (cfg_req_o && $stable(cfg_addr_o) &&
                                       $stable(cfg_we_o) && $stable(cfg_wdata_o)));

    assert_offset_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_o |-> (cfg_addr_o[23:0] == 24'h0));

    assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stop_clr_o));

    assert_clr_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_clr_o) |-> !cfg_req_o);

    assert_clr_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_clr_o) |=> (cfg_req_o && cfg_we_o));

    assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stop_clr_o) |=> (stop_clr_o == '0));

endmodule

bind flr_id_keeper flr_id_keeper_chk #(.NUM_PF(NUM_PF), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_req_o   (cfg_req_o),
    .cfg_we_o    (cfg_we_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_wdata_o (cfg_wdata_o),
    .cfg_ack_i   (cfg_ack_i),
    .stop_clr_o  (stop_clr_o)
);

// File: tb/sim_flr_id_keeper.sv
module sim_flr_id_keeper;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_US    = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        us_tick_i = 1'b1;
    logic [15:0] ltssm_dbg_i = '0;
    logic [1:0]  stop_clr_o;
    logic        cfg_req_o, cfg_we_o;
    logic [31:0] cfg_addr_o, cfg_wdata_o;
    logic        cfg_ack_i;
    logic [31:0] cfg_rdata_i;

    // Environment model state (written only by the model process).
    logic [1:0]  stop_reg;
    logic [31:0] cfg_word [2];
    logic        busy;
    logic [1:0]  wait_cnt;
    logic        lat_idx, lat_we;
    logic [31:0] lat_wdata;
    logic [31:0] log_addr [8];
    logic        log_we   [8];
    logic [31:0] log_data [8];
    int          acc_n;
    logic [1:0]  clr_log [4];
    int          clr_n;

    // Requests from the scenario tasks to the model.
    logic [1:0]  flr_set = '0;
    logic        poke_en = 1'b0;
    logic        poke_idx = 1'b0;
    logic [31:0] poke_val = '0;
    logic        log_clr = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flr_id_keeper #(.WAIT_US(WAIT_US)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .us_tick_i(us_tick_i),
        .ltssm_dbg_i(ltssm_dbg_i), .stop_i(stop_reg), .stop_clr_o(stop_clr_o),
        .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
        .cfg_wdata_o(cfg_wdata_o), .cfg_ack_i(cfg_ack_i), .cfg_rdata_i(cfg_rdata_i)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            stop_reg <= '0; cfg_word[0] <= '0; cfg_word[1] <= '0;
            busy <= 0; wait_cnt <= 0; cfg_ack_i <= 0; cfg_rdata_i <= '0;
            lat_idx <= 0; lat_we <= 0; lat_wdata <= '0; acc_n <= 0; clr_n <= 0;
        end else begin
            stop_reg <= (stop_reg | flr_set) & ~stop_clr_o;
            if (|stop_clr_o) begin
                clr_log[clr_n[1:0]] <= stop_clr_o;
                clr_n <= clr_n + 1;
            end
            if (poke_en) cfg_word[poke_idx] <= poke_val;
            cfg_ack_i <= 1'b0;
            if (cfg_ack_i) begin
                busy <= 1'b0;
            end else if (busy) begin
                if (wait_cnt == 0) begin
                    cfg_ack_i <= 1'b1;
                    if (lat_we) cfg_word[lat_idx] <= lat_wdata;
                    else        cfg_rdata_i <= cfg_word[lat_idx];
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end else if (cfg_req_o) begin
                busy <= 1'b1; wait_cnt <= 2'd1;
                lat_idx <= cfg_addr_o[24]; lat_we <= cfg_we_o; lat_wdata <= cfg_wdata_o;
                log_addr[acc_n[2:0]] <= cfg_addr_o;
                log_we[acc_n[2:0]]   <= cfg_we_o;
                log_data[acc_n[2:0]] <= cfg_wdata_o;
                acc_n <= acc_n + 1;
            end
            if (log_clr) begin acc_n <= 0; clr_n <= 0; end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk); log_clr = 1;
        @(negedge clk); log_clr = 0;
    endtask

    task automatic set_link(input bit l0);
        ltssm_dbg_i = {7'b0, l0 ? 6'h11 : 6'h10, 3'b101};
    endtask

    task automatic raise_flr(input logic [1:0] m);
        @(negedge clk); flr_set = m;
        @(negedge clk); flr_set = '0;
    endtask

    task automatic poke(input logic idx, input logic [31:0] v);
        @(negedge clk); poke_en = 1; poke_idx = idx; poke_val = v;
        @(negedge clk); poke_en = 0;
    endtask

    task automatic run_tick();
        clear_logs();
        @(negedge clk); tick_i = 1;
        @(negedge clk); tick_i = 0;
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset();
        check({31'b0, cfg_req_o}, 0, "R9 cfg_req_o after reset");
        check({30'b0, stop_clr_o}, 0, "R9 stop_clr_o after reset");
    endtask

    task automatic t_no_stop();
        set_link(1);
        run_tick();
        check(acc_n, 0, "R2 accesses with no stop bit");
    endtask

    task automatic t_not_l0();
        poke(0, 32'h9702);
        raise_flr(2'b01);
        set_link(0);
        run_tick();
        check(acc_n, 0, "R1 accesses outside L0");
        check(clr_n, 0, "R1 clears outside L0");
        set_link(1);
    endtask

    task automatic t_capture_pf0();
        run_tick();
        check(acc_n, 1, "R3 capture access count");
        check(log_addr[0], 32'h0000_0000, "R3 capture address pf0");
        check({31'b0, log_we[0]}, 0, "R3 capture is a read");
    endtask

    task automatic t_window();
        run_tick();
        check(acc_n, 0, "R5 no read-back before window expires");
        repeat (WAIT_US + 20) @(negedge clk);
    endtask

    task automatic t_not_reverted();
        run_tick();
        check(acc_n, 1, "R7 read-back count when unchanged");
        check({31'b0, log_we[0]}, 0, "R7 only a read when unchanged");
        check(clr_n, 0, "R7 no clear when unchanged");
        check({30'b0, stop_reg}, 32'h1, "R7 stop bit kept");
    endtask

    task automatic t_reverted();
        poke(0, 32'h9700);
        run_tick();
        check(acc_n, 2, "R7 retried and R6 restore access count");
        check(clr_n, 1, "R6 one clear pulse");
        check({30'b0, clr_log[0]}, 32'h1, "R6 clear mask pf0");
        check({31'b0, log_we[1]}, 1, "R6 second access is a write");
        check(log_data[1], 32'h9702, "R6 restored value");
        check(cfg_word[0], 32'h9702, "R6 word 0 of pf0 after restore");
        check({30'b0, stop_reg}, 0, "R6 stop bit released");
    endtask

    task automatic t_both_functions();
        raise_flr(2'b01);
        run_tick();
        check(acc_n, 0, "R4 no second capture of pf0");
        poke(1, 32'h9702);
        raise_flr(2'b10);
        run_tick();
        check(acc_n, 1, "R3 capture count pf1");
        check(log_addr[0], 32'h0100_0000, "R3 capture address pf1");
        repeat (WAIT_US + 20) @(negedge clk);
        poke(0, 32'h9700);
        poke(1, 32'h9700);
        run_tick();
        check(acc_n, 4, "R8 access count both functions");
        check(log_addr[0], 32'h0000_0000, "R8 first read pf0");
        check(log_addr[1], 32'h0000_0000, "R8 then write pf0");
        check(log_addr[2], 32'h0100_0000, "R8 then read pf1");
        check({31'b0, log_we[3]}, 1, "R8 last is write");
        check(log_addr[3], 32'h0100_0000, "R8 last write pf1");
        check({30'b0, clr_log[0]}, 32'h1, "R8 first clear pf0");
        check({30'b0, clr_log[1]}, 32'h2, "R6 second clear pf1");
        check(cfg_word[1], 32'h9702, "R6 word 0 of pf1 after restore");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_stop();
        t_not_l0();
        t_capture_pf0();
        t_window();
        t_not_reverted();
        t_reverted();
        t_no_stop();
        t_both_functions();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule